// File: doc/BRIEF.md
# Dispatch Group Completion Table

This block follows bundles of instructions, called groups, from the moment they are dispatched until they retire. A group holds up to five instructions, one per slot. When a group is accepted, the block claims the next entry of a circular table. That entry records which slots hold an instruction and which slots write a result. For each writing slot, the block also takes a rename register from a pool of 48 physical registers, numbered 32 to 79 and sitting above the 32 architected ones. The renames for a group are granted all at once or not at all.

Execution units send finish reports back, each naming a group and a slot. The block looks only at the oldest group. Once every occupied slot of that group has finished, it retires the group, shows the group's renames on its retire outputs and puts all of them back into the pool in the same cycle. Younger groups that are already complete wait their turn. Dispatch stalls when all 20 table entries are in use, or when the pool holds fewer renames than the group needs. The only form of recovery is an asynchronous reset that clears everything.

Top module: `group_completion_table`

## Requirements
- R1: Group identifiers are handed out in order 0, 1, …, 19 and then wrap to 0. `disp_gid` always shows the identifier the next accepted group will take.
- R2: At most 20 groups are live at once. While 20 are live, `tbl_full` is high and `disp_ready` is low.
- R3: A group is accepted only in a cycle where `disp_valid` and `disp_ready` are both high. `disp_ready` is low whenever the free rename count is below the number of set bits in `disp_dests`.
- R4: Renames are granted lowest free register first, to the writing slots in ascending slot order. Physical numbers run from 32 to 79. Slot k's register is `disp_preg[7k+6:7k]`, and the field is valid for slots whose `disp_dests` bit is set.
- R5: A finish report on port p marks slot `fin_slot[3p+2:3p]` of group `fin_gid[5p+4:5p]` as finished. The oldest group retires only once every slot set in its `disp_slots` mask has finished, and `retire_valid` rises in the cycle after the last finish is taken.
- R6: Groups retire strictly oldest first. A younger group that is fully finished does not retire while an older group is still incomplete.
- R7: At most one group retires per clock. `retire_gid` names the group that is retiring.
- R8: When a group retires, `retire_dests` and `retire_preg` show its writing slots and their registers. From the next cycle, all of those registers are back in the free pool together.
- R9: After reset the table is empty. `free_count` is 48, `disp_gid` is 0, `retire_valid` and `tbl_full` are low, and `disp_ready` is high.
- R10: `free_count` always equals the number of renames not held by a live group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low, clears the whole table |
| disp_valid | input | 1 | A group is offered for dispatch |
| disp_slots | input | 5 | Slots that hold an instruction |
| disp_dests | input | 5 | Slots that need a rename (subset of disp_slots) |
| disp_ready | output | 1 | The offered group can be accepted this cycle |
| disp_gid | output | 5 | Identifier given to the next accepted group |
| disp_preg | output | 35 | Rename granted to each slot, 7 bits per slot |
| tbl_full | output | 1 | All table entries are live |
| fin_valid | input | 2 | Finish report valid, one bit per port |
| fin_gid | input | 10 | Group of each finish report, 5 bits per port |
| fin_slot | input | 6 | Slot of each finish report, 3 bits per port |
| retire_valid | output | 1 | The oldest group retires at this edge |
| retire_gid | output | 5 | Identifier of the retiring group |
| retire_dests | output | 5 | Writing slots of the retiring group |
| retire_preg | output | 35 | Renames released by the retiring group, 7 bits per slot |
| free_count | output | 6 | Number of renames in the free pool |

## Verification
The assertions assume three things about the inputs. Every finish report names a live group and a slot that is occupied and not yet finished. The two ports never report the same slot in one cycle. A report never targets the entry being dispatched in that cycle. The assertions also assume that `disp_dests` stays inside `disp_slots`. The bench keeps to these rules because it draws each finish only from the unfinished slots of its own model of the live groups. It also never reuses a slot already picked on the other port, and it builds each destination mask by masking the slot mask.

// File: rtl/group_completion_table.sv
`timescale 1ns/1ps
module group_completion_table #(
  parameter int NUM_GROUPS = 20,
  parameter int SLOTS      = 5,
  parameter int ARCH_REGS  = 32,
  parameter int PHYS_REGS  = 80,
  parameter int FIN_PORTS  = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   disp_valid,
  input  logic [SLOTS-1:0]                       disp_slots,
  input  logic [SLOTS-1:0]                       disp_dests,
  output logic                                   disp_ready,
  output logic [$clog2(NUM_GROUPS)-1:0]          disp_gid,
  output logic [SLOTS*$clog2(PHYS_REGS)-1:0]     disp_preg,
  output logic                                   tbl_full,
  input  logic [FIN_PORTS-1:0]                   fin_valid,
  input  logic [FIN_PORTS*$clog2(NUM_GROUPS)-1:0] fin_gid,
  input  logic [FIN_PORTS*$clog2(SLOTS)-1:0]     fin_slot,
  output logic                                   retire_valid,
  output logic [$clog2(NUM_GROUPS)-1:0]          retire_gid,
  output logic [SLOTS-1:0]                       retire_dests,
  output logic [SLOTS*$clog2(PHYS_REGS)-1:0]     retire_preg,
  output logic [$clog2(PHYS_REGS-ARCH_REGS+1)-1:0] free_count
);
  localparam int GW   = $clog2(NUM_GROUPS);
  localparam int SW   = $clog2(SLOTS);
  localparam int PW   = $clog2(PHYS_REGS);
  localparam int NREN = PHYS_REGS - ARCH_REGS;
  localparam int CW   = $clog2(NREN + 1);

  logic [GW-1:0]    head_q, tail_q;
  logic             head_wrap_q, tail_wrap_q;
  logic [SLOTS-1:0] vmask_q [NUM_GROUPS];
  logic [SLOTS-1:0] fmask_q [NUM_GROUPS];
  logic [SLOTS-1:0] dmask_q [NUM_GROUPS];
  logic [PW-1:0]    preg_q  [NUM_GROUPS][SLOTS];
  logic [NREN-1:0]  free_q, avail, alloc_bits, rel_bits;
  logic [CW-1:0]    need_cnt, ret_cnt;
  logic             empty, fire, found;

  function automatic logic [GW-1:0] bump(input logic [GW-1:0] p);
    return (p == GW'(NUM_GROUPS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty        = (head_q == tail_q) && (head_wrap_q == tail_wrap_q);
  assign tbl_full     = (head_q == tail_q) && (head_wrap_q != tail_wrap_q);
  assign disp_gid     = tail_q;
  assign disp_ready   = !tbl_full && (free_count >= need_cnt);
  assign fire         = disp_valid && disp_ready;
  assign retire_valid = !empty && (fmask_q[head_q] == vmask_q[head_q]);
  assign retire_gid   = head_q;
  assign retire_dests = dmask_q[head_q];

  always_comb begin
    free_count = '0;
    for (int r = 0; r < NREN; r++) free_count += CW'(free_q[r]);
    need_cnt = '0;
    ret_cnt  = '0;
    for (int k = 0; k < SLOTS; k++) begin
      need_cnt += CW'(disp_dests[k]);
      ret_cnt  += CW'(dmask_q[head_q][k]);
    end
  end

  always_comb begin
    avail      = free_q;
    alloc_bits = '0;
    disp_preg  = '0;
    found      = 1'b0;
    for (int k = 0; k < SLOTS; k++) begin
      if (disp_dests[k]) begin
        found = 1'b0;
        for (int r = 0; r < NREN; r++) begin
          if (!found && avail[r]) begin
            found              = 1'b1;
            avail[r]           = 1'b0;
            alloc_bits[r]      = 1'b1;
            disp_preg[k*PW +: PW] = PW'(ARCH_REGS + r);
          end
        end
      end
    end
  end

  always_comb begin
    rel_bits    = '0;
    retire_preg = '0;
    for (int k = 0; k < SLOTS; k++) begin
      retire_preg[k*PW +: PW] = preg_q[head_q][k];
      if (dmask_q[head_q][k]) begin
        for (int r = 0; r < NREN; r++)
          if (int'(preg_q[head_q][k]) == ARCH_REGS + r) rel_bits[r] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q      <= '0;
      tail_q      <= '0;
      head_wrap_q <= 1'b0;
      tail_wrap_q <= 1'b0;
      free_q      <= '1;
      for (int i = 0; i < NUM_GROUPS; i++) begin
        vmask_q[i] <= '0;
        fmask_q[i] <= '0;
        dmask_q[i] <= '0;
        for (int k = 0; k < SLOTS; k++) preg_q[i][k] <= '0;
      end
    end else begin
      if (fire) begin
        vmask_q[tail_q] <= disp_slots;
        fmask_q[tail_q] <= '0;
        dmask_q[tail_q] <= disp_dests;
        for (int k = 0; k < SLOTS; k++) preg_q[tail_q][k] <= disp_preg[k*PW +: PW];
        tail_q <= bump(tail_q);
        if (tail_q == GW'(NUM_GROUPS - 1)) tail_wrap_q <= !tail_wrap_q;
      end
      for (int p = 0; p < FIN_PORTS; p++) begin
        if (fin_valid[p] && fin_gid[p*GW +: GW] < GW'(NUM_GROUPS)
            && fin_slot[p*SW +: SW] < SW'(SLOTS))
          fmask_q[fin_gid[p*GW +: GW]][fin_slot[p*SW +: SW]] <= 1'b1;
      end
      if (retire_valid) begin
        head_q <= bump(head_q);
        if (head_q == GW'(NUM_GROUPS - 1)) head_wrap_q <= !head_wrap_q;
      end
      free_q <= (free_q & ~(fire ? alloc_bits : '0)) | (retire_valid ? rel_bits : '0);
    end
  end

  logic [GW:0]           occ_q;
  logic [NUM_GROUPS-1:0] live;
  int                    held_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_q + (GW+1)'(fire) - (GW+1)'(retire_valid);
  end

  always_comb begin
    held_cnt = 0;
    for (int i = 0; i < NUM_GROUPS; i++) begin
      live[i] = ((i - int'(head_q) + NUM_GROUPS) % NUM_GROUPS) < int'(occ_q);
      if (live[i]) held_cnt += $countones(dmask_q[i]);
    end
  end

  // R2
  occ_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(occ_q) <= NUM_GROUPS) && ((int'(occ_q) == NUM_GROUPS) == tbl_full));

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> (tail_q == $past(tail_q)) && (free_count >= $past(free_count)));

  // R6
  retire_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |=> head_q == (($past(head_q) == GW'(NUM_GROUPS - 1)) ? '0 : $past(head_q) + 1'b1));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && !fire) |=> free_count == $past(free_count) + $past(ret_cnt));

  // R10
  pool_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_count) + held_cnt == NREN);

  for (genvar p = 0; p < FIN_PORTS; p++) begin : g_fin_chk
    // R5
    fin_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin_valid[p] |-> (fin_gid[p*GW +: GW] < GW'(NUM_GROUPS)) && live[fin_gid[p*GW +: GW]]
        && vmask_q[fin_gid[p*GW +: GW]][fin_slot[p*SW +: SW]]
        && !fmask_q[fin_gid[p*GW +: GW]][fin_slot[p*SW +: SW]]);
  end
endmodule

// File: tb/group_completion_table_bench.sv
`timescale 1ns/1ps
module group_completion_table_bench;
  localparam int NG = 20, SL = 5, PW = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disp_valid = 1'b0;
  logic [4:0]  disp_slots = '0, disp_dests = '0;
  logic        disp_ready, tbl_full, retire_valid;
  logic [4:0]  disp_gid, retire_gid, retire_dests;
  logic [34:0] disp_preg, retire_preg;
  logic [1:0]  fin_valid = '0;
  logic [9:0]  fin_gid = '0;
  logic [5:0]  fin_slot = '0;
  logic [5:0]  free_count;

  always #2.5 clk = ~clk;

  group_completion_table u_group_completion_table (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_slots(disp_slots),
    .disp_dests(disp_dests), .disp_ready(disp_ready), .disp_gid(disp_gid),
    .disp_preg(disp_preg), .tbl_full(tbl_full), .fin_valid(fin_valid),
    .fin_gid(fin_gid), .fin_slot(fin_slot), .retire_valid(retire_valid),
    .retire_gid(retire_gid), .retire_dests(retire_dests), .retire_preg(retire_preg),
    .free_count(free_count));

  int checks = 0, fails = 0;
  bit done = 0;
  int m_head, m_cnt;
  bit [4:0] m_v [NG], m_f [NG], m_d [NG];
  int m_p [NG][SL];
  bit [47:0] m_free;

  task automatic expect_eq(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_head = 0; m_cnt = 0; m_free = '1;
    for (int i = 0; i < NG; i++) begin
      m_v[i] = 0; m_f[i] = 0; m_d[i] = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; disp_valid = 0; fin_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    #1;
    expect_eq("R9 free_count after reset", free_count, 48);
    expect_eq("R9 tbl_full after reset", tbl_full, 0);
    expect_eq("R9 retire_valid after reset", retire_valid, 0);
    expect_eq("R9 disp_gid after reset", disp_gid, 0);
    expect_eq("R9 disp_ready after reset", disp_ready, 1);
  endtask

  task automatic drive(input bit dv, input bit [4:0] sl, input bit [4:0] ds, input bit [1:0] fv,
                       input int g0, input int s0, input int g1, input int s1);
    bit full, er, rt, young_done;
    int fn, need, h, g;
    int ep [SL];
    bit [47:0] nf;
    @(negedge clk);
    disp_valid = dv; disp_slots = sl; disp_dests = ds;
    fin_valid = fv;
    fin_gid = {5'(g1), 5'(g0)};
    fin_slot = {3'(s1), 3'(s0)};
    #1;
    full = (m_cnt == NG);
    need = $countones(ds);
    fn = $countones(m_free);
    er = !full && fn >= need;
    expect_eq(full ? "R2 ready while full" : "R3 ready vs free renames", disp_ready, er);
    expect_eq("R2 tbl_full", tbl_full, full);
    expect_eq("R10 free_count", free_count, fn);
    expect_eq("R1 disp_gid", disp_gid, (m_head + m_cnt) % NG);
    nf = m_free;
    for (int k = 0; k < SL; k++) begin
      ep[k] = 0;
      if (ds[k]) begin
        for (int r = 0; r < 48; r++) if (ep[k] == 0 && nf[r]) begin ep[k] = 32 + r; nf[r] = 0; end
        if (dv && er) expect_eq("R4 granted rename", disp_preg[k*PW +: PW], ep[k]);
      end
    end
    h = m_head;
    rt = m_cnt > 0 && m_f[h] == m_v[h];
    young_done = 0;
    for (int o = 1; o < m_cnt; o++) begin
      g = (m_head + o) % NG;
      if (m_f[g] == m_v[g]) young_done = 1;
    end
    expect_eq((!rt && young_done) ? "R6 younger waits for oldest" : "R5 retire when all finished",
              retire_valid, rt);
    if (rt) begin
      expect_eq("R7 retire_gid", retire_gid, h);
      expect_eq("R8 retire_dests", retire_dests, m_d[h]);
      for (int k = 0; k < SL; k++)
        if (m_d[h][k]) expect_eq("R8 retire_preg", retire_preg[k*PW +: PW], m_p[h][k]);
    end
    @(posedge clk);
    if (fv[0]) m_f[g0][s0] = 1;
    if (fv[1]) m_f[g1][s1] = 1;
    if (dv && er) begin
      g = (m_head + m_cnt) % NG;
      m_v[g] = sl; m_f[g] = 0; m_d[g] = ds;
      for (int k = 0; k < SL; k++) m_p[g][k] = ep[k];
      m_free = nf;
      m_cnt++;
    end
    if (rt) begin
      for (int k = 0; k < SL; k++) if (m_d[h][k]) m_free[m_p[h][k] - 32] = 1;
      m_head = (m_head + 1) % NG;
      m_cnt--;
    end
  endtask

  task automatic rstep(input int dp, input int fp, input int dm);
    bit dv;
    bit [4:0] sl, ds, u;
    bit [1:0] fv;
    int gs [2], ss [2];
    dv = ($urandom % 100) < dp;
    sl = 5'($urandom);
    if (sl == 0) sl = 5'b00001;
    case (dm)
      1: ds = sl & (~sl + 5'd1);
      2: begin sl = 5'h1f; ds = 5'h1f; end
      default: ds = sl & 5'($urandom);
    endcase
    fv = 0; gs[0] = 0; gs[1] = 0; ss[0] = 0; ss[1] = 0;
    for (int p = 0; p < 2; p++) begin
      if (m_cnt > 0 && ($urandom % 100) < fp) begin
        int g, st;
        g = (m_head + int'($urandom % m_cnt)) % NG;
        u = m_v[g] & ~m_f[g];
        if (p == 1 && fv[0] && g == gs[0]) u[ss[0]] = 0;
        st = $urandom % SL;
        for (int j = 0; j < SL; j++) begin
          int s;
          s = (st + j) % SL;
          if (!fv[p] && u[s]) begin fv[p] = 1; gs[p] = g; ss[p] = s; end
        end
      end
    end
    drive(dv, sl, ds, fv, gs[0], ss[0], gs[1], ss[1]);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int ga, gb;
    void'($urandom(32'd2024));
    do_reset();
    // R2: fill the table without finishing anything
    repeat (26) rstep(100, 0, 1);
    repeat (80) rstep(0, 100, 0);
    // R3: run the rename pool dry with five-writer groups
    repeat (14) rstep(100, 0, 2);
    repeat (80) rstep(0, 100, 0);
    // R6, R7: the younger group finishes first
    ga = (m_head + m_cnt) % NG;
    gb = (ga + 1) % NG;
    drive(1, 5'b00001, 5'b00001, 0, 0, 0, 0, 0);
    drive(1, 5'b00001, 5'b00001, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 2'b01, gb, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 2'b01, ga, 0, 0, 0);
    repeat (3) drive(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3000) rstep(60, 70, 0);
    repeat (1500) rstep(80, 30, 0);
    // R9: reset while the table is busy
    do_reset();
    repeat (500) rstep(60, 70, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule